// File: doc/BRIEF.md
# Stored-Batch FIR Filter

This block applies a 51-tap finite impulse response filter, with coefficients held in registers, to a batch of signed 16-bit samples that a host has already placed in an on-chip sample memory. It is not a streaming filter. The host writes the samples through a simple write port, loads the coefficients while the block is idle, sets the index of the last sample of the batch and pulses `start`.

The block then reads the sample memory one address per cycle, in ascending order. Each sample is read exactly once. Every sample read is shifted into a register window of the 51 most recent samples. All 51 tap products are formed in the same cycle, summed at full precision and written to a result memory at the index of the newest sample. The history before sample 0 counts as zero. When the last result has been written, `done` pulses for one cycle. The host then reads the results through a registered read port.

Top module: `fir_batch_top`

## Requirements
- R1: Result n equals the sum over k = 0..50 of coef[k] * x[n-k], where coefficient index k weights the sample k positions older than sample n. Any sample with a negative index counts as zero.
- R2: Results are 38-bit signed two's-complement values at full precision. They do not overflow or saturate, even when every sample and every coefficient is -32768.
- R3: Every batch starts from a cleared window, so no sample from an earlier batch affects any result of a later batch.
- R4: `busy` rises in the cycle after `start` is accepted and stays high for exactly last_idx + 5 cycles. `done` is high for exactly one cycle, which is the first cycle in which `busy` is low again.
- R5: A `start` pulse while `busy` is high is ignored. It does not restart or extend the batch.
- R6: A coefficient write is ignored while `busy` is high. A coefficient write to an index of 51 or above is ignored at all times.
- R7: A sample-memory write is ignored while `busy` is high.
- R8: Result n is stored at result address n. Presenting an address on `res_addr` gives that entry on `res_data` after the next rising clock edge.
- R9: After reset, `busy` and `done` are low and all coefficients are zero, so a batch run before any coefficient load gives all-zero results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_we | input | 1 | Sample memory write enable |
| smp_addr | input | 6 | Sample memory write address |
| smp_data | input | 16 | Signed sample to store |
| coef_we | input | 1 | Coefficient write enable |
| coef_idx | input | 6 | Tap index to load (0..50 valid) |
| coef_data | input | 16 | Signed coefficient value |
| last_idx | input | 6 | Index of the last sample of the batch, sampled at start |
| start | input | 1 | Begin a batch (single-cycle pulse) |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle pulse after the last result write |
| res_addr | input | 6 | Result memory read address |
| res_data | output | 38 | Signed result read one cycle after the address |

## Verification
The assertions assume that `start` arrives only as a single-cycle pulse and that the sample and coefficient ports are driven with defined values whenever their enables are high. The stimulus changes inputs only on falling clock edges, holds every write enable for one cycle, and pulses `start` exactly once per batch, plus once more on purpose while `busy` is high. The assertions also assume that `last_idx` is stable at the moment a batch starts. The bench sets it before the `start` pulse and only moves it between batches.

// File: rtl/fir_batch_pkg.sv
// Package: shared types for the stored-batch FIR filter.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package fir_batch_pkg;

    // Sequencer states of the batch controller
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_t;

    // Width of a sign-extension pad that keeps a sum of n terms exact
    function automatic int growth_bits(input int n_terms);
        return $clog2(n_terms);
    endfunction

endpackage

// File: rtl/fir_sdp_ram.sv
// Module: simple dual-port memory, one write port and one registered read port.
// Assumes: write and read share one clock; reading an address written in the
// same cycle returns the old contents. No reset on the storage array.
module fir_sdp_ram #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    // Write port: store one word per enabled cycle
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Read port: registered output, one cycle of latency
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem_q[raddr];
        end
    end

endmodule

// File: rtl/fir_batch_ctrl.sv
// Module: batch sequencer. Issues one sample read per cycle for indices
// 0..last, tracks the four-stage valid pipeline behind the read, counts result
// writes and produces busy/done.
// Assumes: start is a pulse; last_idx is stable in the cycle start is high.
module fir_batch_ctrl
    import fir_batch_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] last_idx,
    output logic              busy,
    output logic              done,
    output logic              clear,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              shift_en,
    output logic              mul_en,
    output logic              sum_en,
    output logic              res_we,
    output logic [ADDR_W-1:0] res_addr
);

    localparam int PIPE_N = 4;

    seq_state_t        state_q;
    logic [ADDR_W-1:0] rd_idx_q;
    logic [ADDR_W-1:0] wr_idx_q;
    logic [ADDR_W-1:0] last_q;
    logic [PIPE_N-1:0] vld_q;
    logic              busy_q;
    logic              done_q;

    // Combinational decodes of state and valid pipeline
    always_comb begin
        clear    = (state_q == SEQ_IDLE) && start;
        rd_en    = (state_q == SEQ_READ);
        rd_addr  = rd_idx_q;
        shift_en = vld_q[0];
        mul_en   = vld_q[1];
        sum_en   = vld_q[2];
        res_we   = vld_q[3];
        res_addr = wr_idx_q;
        busy     = busy_q;
        done     = done_q;
    end

    // Sequencer, valid pipeline, write counter and handshake flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            rd_idx_q <= '0;
            wr_idx_q <= '0;
            last_q   <= '0;
            vld_q    <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            vld_q  <= {vld_q[PIPE_N-2:0], rd_en};
            if (res_we) begin
                wr_idx_q <= wr_idx_q + ADDR_W'(1);
            end
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q  <= SEQ_READ;
                        busy_q   <= 1'b1;
                        rd_idx_q <= '0;
                        wr_idx_q <= '0;
                        last_q   <= last_idx;
                    end
                end
                SEQ_READ: begin
                    if (rd_idx_q == last_q) begin
                        state_q <= SEQ_DRAIN;
                    end else begin
                        rd_idx_q <= rd_idx_q + ADDR_W'(1);
                    end
                end
                SEQ_DRAIN: begin
                    if (res_we && (wr_idx_q == last_q)) begin
                        state_q <= SEQ_IDLE;
                        busy_q  <= 1'b0;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R4
    AST_DONE_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_q) && !busy_q) |-> done_q); // R4
    AST_READS_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_READ && $past(state_q == SEQ_READ)) |-> (rd_idx_q == $past(rd_idx_q) + ADDR_W'(1))); // R5
    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> (busy_q && wr_idx_q <= last_q)); // R8

endmodule

// File: rtl/fir_tap_window.sv
// Module: coefficient registers, the 51-deep sample window and the parallel
// tap multipliers. The newest sample sits in slot 0; slot k holds the sample
// k positions older and is weighted by coefficient k.
// Assumes: clear and shift_en never coincide (clear only happens when idle).
module fir_tap_window #(
    parameter int NTAPS  = 51,
    parameter int DW     = 16,
    parameter int CW     = 16,
    parameter int TIDX_W = 6,
    localparam int PW    = DW + CW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       busy,
    input  logic                       coef_we,
    input  logic [TIDX_W-1:0]          coef_idx,
    input  logic [CW-1:0]              coef_data,
    input  logic                       clear,
    input  logic                       shift_en,
    input  logic [DW-1:0]              sample_in,
    input  logic                       mul_en,
    output logic [NTAPS-1:0][PW-1:0]   prods
);

    logic [NTAPS-1:0][CW-1:0] coef_q;
    logic [NTAPS-1:0][DW-1:0] win_q;
    logic                     coef_ok;

    // Coefficient writes accepted only when idle and in range
    always_comb begin
        coef_ok = coef_we && !busy && (int'(coef_idx) < NTAPS);
    end

    // Coefficient register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_q <= '0;
        end else if (coef_ok) begin
            coef_q[coef_idx] <= coef_data;
        end
    end

    // Sample window: cleared at batch start, shifted once per sample read
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            win_q <= '0;
        end else if (shift_en) begin
            win_q[0] <= sample_in;
            for (int k = 1; k < NTAPS; k++) begin
                win_q[k] <= win_q[k-1];
            end
        end
    end

    // One registered signed multiplier per tap
    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prods[g] <= '0;
            end else if (mul_en) begin
                prods[g] <= PW'($signed(win_q[g]) * $signed(coef_q[g]));
            end
        end
    end

    AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(coef_q)); // R6

endmodule

// File: rtl/fir_adder_tree.sv
// Module: full-precision sum of all tap products into one registered result.
// Assumes: products are signed two's complement of width PW; ACC_W leaves
// enough headroom for NTAPS terms.
module fir_adder_tree #(
    parameter int NTAPS = 51,
    parameter int PW    = 32,
    parameter int ACC_W = 38,
    localparam int EXT  = ACC_W - PW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [NTAPS-1:0][PW-1:0] prods,
    output logic [ACC_W-1:0]         acc
);

    logic [NTAPS-1:0][ACC_W-1:0] ext_w;
    logic [ACC_W-1:0]            sum_w;

    // Sign-extend each product to the accumulator width
    for (genvar g = 0; g < NTAPS; g++) begin : g_ext
        assign ext_w[g] = {{EXT{prods[g][PW-1]}}, prods[g]};
    end

    // Sum all extended products
    always_comb begin
        sum_w = '0;
        for (int k = 0; k < NTAPS; k++) begin
            sum_w = sum_w + ext_w[k];
        end
    end

    // Register the sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en) begin
            acc <= sum_w;
        end
    end

endmodule

// File: rtl/fir_batch_top.sv
// Module: stored-batch FIR filter top. Sample memory -> tap window and
// multipliers -> adder -> result memory, driven by the batch sequencer.
// Assumes: the host loads samples and coefficients while busy is low and
// reads results after done.
module fir_batch_top
    import fir_batch_pkg::*;
#(
    parameter int NTAPS = 51,
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 64,
    localparam int AW     = $clog2(DEPTH),
    localparam int TIDX_W = $clog2(NTAPS),
    localparam int PW     = DW + CW,
    localparam int ACC_W  = PW + growth_bits(NTAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_we,
    input  logic [AW-1:0]     smp_addr,
    input  logic [DW-1:0]     smp_data,
    input  logic              coef_we,
    input  logic [TIDX_W-1:0] coef_idx,
    input  logic [CW-1:0]     coef_data,
    input  logic [AW-1:0]     last_idx,
    input  logic              start,
    output logic              busy,
    output logic              done,
    input  logic [AW-1:0]     res_addr,
    output logic [ACC_W-1:0]  res_data
);

    logic                     clear;
    logic                     rd_en;
    logic [AW-1:0]            rd_addr;
    logic                     shift_en;
    logic                     mul_en;
    logic                     sum_en;
    logic                     res_we;
    logic [AW-1:0]            res_waddr;
    logic [DW-1:0]            smp_q;
    logic [NTAPS-1:0][PW-1:0] prods;
    logic [ACC_W-1:0]         acc;
    logic                     smp_we_ok;

    // Sample loads are blocked for the whole batch
    always_comb begin
        smp_we_ok = smp_we && !busy;
    end

    fir_batch_ctrl #(.ADDR_W(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .last_idx (last_idx),
        .busy     (busy),
        .done     (done),
        .clear    (clear),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .shift_en (shift_en),
        .mul_en   (mul_en),
        .sum_en   (sum_en),
        .res_we   (res_we),
        .res_addr (res_waddr)
    );

    fir_sdp_ram #(.WIDTH(DW), .DEPTH(DEPTH)) u_smp_ram (
        .clk   (clk),
        .we    (smp_we_ok),
        .waddr (smp_addr),
        .wdata (smp_data),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (smp_q)
    );

    fir_tap_window #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .TIDX_W(TIDX_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .coef_we   (coef_we),
        .coef_idx  (coef_idx),
        .coef_data (coef_data),
        .clear     (clear),
        .shift_en  (shift_en),
        .sample_in (smp_q),
        .mul_en    (mul_en),
        .prods     (prods)
    );

    fir_adder_tree #(.NTAPS(NTAPS), .PW(PW), .ACC_W(ACC_W)) u_adder (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sum_en),
        .prods (prods),
        .acc   (acc)
    );

    fir_sdp_ram #(.WIDTH(ACC_W), .DEPTH(DEPTH)) u_res_ram (
        .clk   (clk),
        .we    (res_we),
        .waddr (res_waddr),
        .wdata (acc),
        .re    (1'b1),
        .raddr (res_addr),
        .rdata (res_data)
    );

    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && smp_we) |-> !smp_we_ok); // R7

endmodule

// File: tb/fir_batch_top_bench.sv
`timescale 1ns/1ps
module fir_batch_top_bench;

    localparam int NTAPS = 51;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_we;
    logic [5:0]  smp_addr;
    logic [15:0] smp_data;
    logic        coef_we;
    logic [5:0]  coef_idx;
    logic [15:0] coef_data;
    logic [5:0]  last_idx;
    logic        start;
    logic        busy;
    logic        done;
    logic [5:0]  res_addr;
    logic [37:0] res_data;

    int errors = 0;
    int checks = 0;

    // Behavioural reference state
    int smp_m  [DEPTH];
    int coef_m [NTAPS];
    bit m_busy;
    bit m_done;
    int m_left;

    always #4 clk = ~clk;

    fir_batch_top u_fir_batch_top (
        .clk(clk), .rst_n(rst_n),
        .smp_we(smp_we), .smp_addr(smp_addr), .smp_data(smp_data),
        .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
        .last_idx(last_idx), .start(start),
        .busy(busy), .done(done),
        .res_addr(res_addr), .res_data(res_data)
    );

    // Reference model: handshake timing and the writes it accepts
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_done <= 1'b0;
            m_left <= 0;
            for (int k = 0; k < NTAPS; k++) coef_m[k] <= 0;
        end else begin
            if (smp_we && !m_busy) smp_m[smp_addr] <= $signed(smp_data);
            if (coef_we && !m_busy && coef_idx < NTAPS) coef_m[coef_idx] <= $signed(coef_data);
            if (!m_busy) begin
                m_done <= 1'b0;
                if (start) begin
                    m_busy <= 1'b1;
                    m_left <= int'(last_idx) + 5;
                end
            end else begin
                if (m_left == 1) begin
                    m_busy <= 1'b0;
                    m_done <= 1'b1;
                end
                m_left <= m_left - 1;
            end
        end
    end

    // Per-cycle comparison of the handshake outputs (R4, R5)
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (busy !== m_busy || done !== m_done) begin
                errors++;
                $display("FAIL R4/R5 handshake at %0t: busy=%b done=%b expected busy=%b done=%b",
                         $time, busy, done, m_busy, m_done);
            end
        end
    end

    task automatic put_sample(input int a, input int v);
        smp_we = 1'b1; smp_addr = 6'(a); smp_data = 16'(v);
        @(negedge clk);
        smp_we = 1'b0;
    endtask

    task automatic put_coef(input int i, input int v);
        coef_we = 1'b1; coef_idx = 6'(i); coef_data = 16'(v);
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    // Run one batch; optionally disturb it while busy (R5, R6, R7)
    task automatic run_batch(input int last, input bit disturb);
        last_idx = 6'(last);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            start = 1'b1; coef_we = 1'b1; coef_idx = 6'd3; coef_data = 16'd7777;
            smp_we = 1'b1; smp_addr = 6'd2; smp_data = 16'd1234;
            @(negedge clk);
            start = 1'b0; coef_we = 1'b0; smp_we = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // Compare all results of the last batch against the model (R1, R8)
    task automatic check_results(input int last, input string tag);
        for (int n = 0; n <= last; n++) begin
            longint expv = 0;
            for (int k = 0; k < NTAPS; k++) begin
                if (n - k >= 0) expv += longint'(coef_m[k]) * longint'(smp_m[n-k]);
            end
            res_addr = 6'(n);
            @(negedge clk);
            checks++;
            if (longint'($signed(res_data)) != expv) begin
                errors++;
                $display("FAIL %s result[%0d]: got %0d expected %0d",
                         tag, n, longint'($signed(res_data)), expv);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; smp_we = 1'b0; smp_addr = '0; smp_data = '0;
        coef_we = 1'b0; coef_idx = '0; coef_data = '0;
        last_idx = '0; start = 1'b0; res_addr = '0;
        for (int a = 0; a < DEPTH; a++) smp_m[a] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state of the handshake outputs
        checks++;
        if (busy !== 1'b0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset: busy=%b done=%b expected 0 0", busy, done);
        end

        // R9: no coefficients loaded yet -> all-zero results
        for (int a = 0; a < DEPTH; a++) put_sample(a, a * 37 - 900);
        run_batch(20, 1'b0);
        check_results(20, "R9 zero coefs");

        // R1: impulse response reveals tap order (result n = coef[n])
        for (int k = 0; k < NTAPS; k++) put_coef(k, (k + 1) * 3 - 40);
        for (int a = 0; a < DEPTH; a++) put_sample(a, (a == 0) ? 1 : 0);
        run_batch(60, 1'b0);
        check_results(60, "R1 impulse");

        // R1, R8: mixed data across the full memory
        for (int a = 0; a < DEPTH; a++) put_sample(a, int'($urandom_range(65535)) - 32768);
        for (int k = 0; k < NTAPS; k++) put_coef(k, int'($urandom_range(65535)) - 32768);
        run_batch(DEPTH - 1, 1'b0);
        check_results(DEPTH - 1, "R1/R8 mixed");

        // R3: short batch right after a full one, history must be cleared
        run_batch(3, 1'b0);
        check_results(3, "R3 cleared window");

        // R4: single-sample batch
        run_batch(0, 1'b0);
        check_results(0, "R4 single sample");

        // R2: extreme values, largest magnitude sum
        for (int a = 0; a < DEPTH; a++) put_sample(a, -32768);
        for (int k = 0; k < NTAPS; k++) put_coef(k, -32768);
        run_batch(DEPTH - 1, 1'b0);
        check_results(DEPTH - 1, "R2 extremes");

        // R5, R6, R7: start, coefficient and sample writes while busy are ignored
        for (int a = 0; a < DEPTH; a++) put_sample(a, (a % 7) * 101 - 300);
        for (int k = 0; k < NTAPS; k++) put_coef(k, k * 11 - 250);
        run_batch(30, 1'b1);
        check_results(30, "R5 restart ignored");
        run_batch(30, 1'b0);
        check_results(30, "R6/R7 busy writes ignored");

        // R6: out-of-range coefficient index has no effect
        put_coef(55, 20000);
        put_coef(63, -20000);
        run_batch(DEPTH - 1, 1'b0);
        check_results(DEPTH - 1, "R6 index out of range");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule